// File: doc/BRIEF.md
# Eight-Bit Accumulator Arithmetic Unit with Decimal Correction

This block is the arithmetic core of a small byte-wide processor. It owns an accumulator A, a helper register B and a status byte, and it applies one operation per accepted start strobe. The operation comes from a 4-bit select, and a byte operand supplies the second source. Binary add, add with carry-in, subtract with borrow, increment, decrement and packed-BCD correction finish in a single clock. Unsigned multiply and divide run over several clocks on an iterative datapath, and each splits its result across A and B. Three load operations set A, B and the writable status fields, so a sequencer can stage operands and flags.

Every completed operation raises a one-cycle done pulse. While a multiply or divide is in flight, a new start strobe has no effect. Selects 0xB to 0xF are unassigned. They complete in one clock and change no state.

Top module: `acc_alu`

## Requirements
- R1: After reset, A, B and the status byte are 0x00 and done is low.
- R2: Select 0x8 loads A from the operand, and 0x9 loads B. Select 0xA loads the status byte from operand bits 7 (CY), 6 (AC), 5 (F0), 4:3 (bank select), 2 (OV). Status bit 1 always reads 0. Status bit 0 is the parity bit P.
- R3: Select 0x0 (add) and 0x1 (add plus CY) write the low byte of the sum into A. They set CY to the carry out of bit 7, AC to the carry out of bit 3, and OV to the two's-complement overflow.
- R4: Select 0x2 writes A − operand − CY into A. It sets CY to the borrow out of bit 7, AC to the borrow out of bit 3, and OV to the two's-complement overflow.
- R5: Select 0x3 adds one to A and select 0x4 subtracts one, wrapping 0xFF→0x00 and 0x00→0xFF. CY, AC and OV are left unchanged.
- R6: Select 0x5 multiplies A by B as unsigned numbers. It puts the low byte in A and the high byte in B, clears CY, and sets OV exactly when the product exceeds 0xFF. Done is seen after the fifth rising edge counted from the start edge.
- R7: Select 0x6 divides A by a nonzero B. It puts the quotient in A and the remainder in B and clears CY and OV. Done is seen after the ninth rising edge counted from the start edge.
- R8: Dividing by B = 0x00 sets OV and clears CY. A and B are then unspecified.
- R9: Select 0x7 adds 0x06 if the low nibble of A exceeds 9 or AC is set. It then adds 0x60 if the resulting high nibble exceeds 9, or CY is set, or the first step carried out. CY is set by a carry out of the second step and is never cleared.
- R10: Status bit P always equals the XOR of the eight bits of A.
- R11: A start strobe during a multiply or divide is ignored. Unassigned selects 0xB to 0xF change neither A, B nor the status byte.
- R12: Done is high for one cycle per accepted operation; single-clock operations show it after the start edge. F0 and the bank select change only through select 0xA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start strobe, sampled when the unit is idle |
| op_i | input | 4 | Operation select |
| opnd_i | input | 8 | Operand byte |
| a_o | output | 8 | Accumulator A |
| b_o | output | 8 | Helper register B |
| psw_o | output | 8 | Status byte {CY, AC, F0, RS[1:0], OV, 0, P} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that increment and decrement leave CY untouched and that F0 and the bank bits hold except on a status load. They also check that A and B stay still while the iterative unit is busy, that done follows exactly the accepted or finished operations, and that the step counter stays in range. Numeric results can only be shown by the bench's scenarios. These include the arithmetic and flag values of every operation under random operands and the decimal-correction corners, as well as multiply overflow, divide by zero and the exact multi-cycle latencies.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned DATA_W = 8;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0,
    OP_ADDC  = 4'h1,
    OP_SUBB  = 4'h2,
    OP_INC   = 4'h3,
    OP_DEC   = 4'h4,
    OP_MUL   = 4'h5,
    OP_DIV   = 4'h6,
    OP_DA    = 4'h7,
    OP_LDA   = 4'h8,
    OP_LDB   = 4'h9,
    OP_LDPSW = 4'hA
  } op_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] opnd,
  input  logic         cy_i,
  input  logic         ac_i,
  output logic [W-1:0] res,
  output logic         cy_o,
  output logic         ac_o,
  output logic         ov_o
);

  localparam int unsigned NIB = 4;
  localparam logic [W:0] LO_FIX = (W+1)'(6);
  localparam logic [W:0] HI_FIX = (W+1)'(6) << NIB;

  logic         cin;
  logic [W:0]   sum_w, dif_w, da_t1, da_t2;
  logic [NIB:0] sum_n, dif_n;
  logic         lo_adj, hi_adj;

  always_comb begin
    cin   = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_i : 1'b0;
    sum_w = {1'b0, a} + {1'b0, opnd} + {{W{1'b0}}, cin};
    dif_w = {1'b0, a} - {1'b0, opnd} - {{W{1'b0}}, cin};
    sum_n = {1'b0, a[NIB-1:0]} + {1'b0, opnd[NIB-1:0]} + {{NIB{1'b0}}, cin};
    dif_n = {1'b0, a[NIB-1:0]} - {1'b0, opnd[NIB-1:0]} - {{NIB{1'b0}}, cin};

    lo_adj = (a[NIB-1:0] > NIB'(9)) || ac_i;
    da_t1  = {1'b0, a} + (lo_adj ? LO_FIX : '0);
    hi_adj = (da_t1[W-1:W-NIB] > NIB'(9)) || cy_i || da_t1[W];
    da_t2  = da_t1 + (hi_adj ? HI_FIX : '0);

    res  = a;
    cy_o = cy_i;
    ac_o = ac_i;
    ov_o = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        res  = sum_w[W-1:0];
        cy_o = sum_w[W];
        ac_o = sum_n[NIB];
        ov_o = (a[W-1] == opnd[W-1]) && (sum_w[W-1] != a[W-1]);
      end
      OP_SUBB: begin
        res  = dif_w[W-1:0];
        cy_o = dif_w[W];
        ac_o = dif_n[NIB];
        ov_o = (a[W-1] != opnd[W-1]) && (dif_w[W-1] != a[W-1]);
      end
      OP_INC:  res = a + W'(1);
      OP_DEC:  res = a - W'(1);
      OP_DA: begin
        res  = da_t2[W-1:0];
        cy_o = cy_i | da_t2[W];
      end
      default: res = a;
    endcase
  end

endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv #(
  parameter int unsigned W       = 8,
  parameter int unsigned STEP_SB = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         is_div,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         ov
);

  localparam int unsigned MUL_STEPS = W / STEP_SB;
  localparam int unsigned DIV_STEPS = W;
  localparam int unsigned CW        = $clog2(DIV_STEPS + 1);
  localparam int unsigned PW        = W + STEP_SB;

  logic          busy_q, busy_d;
  logic          div_q, div_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2*W-1:0] acc_q, acc_d, acc_nx;
  logic [W-1:0]  mpl_q, mpl_d;
  logic [W-1:0]  dvs_q, dvs_d;

  logic [PW-1:0]  pp;
  logic [2*W-1:0] pp_sh;
  logic [W:0]     rem_sh, rem_nx;
  logic [W-1:0]   quo_nx;
  int unsigned    idx;

  // one iteration of the selected datapath
  always_comb begin
    idx    = MUL_STEPS - 32'(cnt_q);
    pp     = {{STEP_SB{1'b0}}, dvs_q} * {{W{1'b0}}, mpl_q[STEP_SB-1:0]};
    pp_sh  = {{(2*W-PW){1'b0}}, pp} << (STEP_SB * idx);
    rem_sh = {acc_q[2*W-1:W], acc_q[W-1]};
    quo_nx = {acc_q[W-2:0], 1'b0};
    rem_nx = rem_sh;
    if (rem_sh >= {1'b0, dvs_q}) begin
      rem_nx    = rem_sh - {1'b0, dvs_q};
      quo_nx[0] = 1'b1;
    end
    if (div_q) acc_nx = {rem_nx[W-1:0], quo_nx};
    else       acc_nx = acc_q + pp_sh;
  end

  always_comb begin
    busy_d = busy_q;
    div_d  = div_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    mpl_d  = mpl_q;
    dvs_d  = dvs_q;
    if (ld) begin
      busy_d = 1'b1;
      div_d  = is_div;
      cnt_d  = is_div ? CW'(DIV_STEPS) : CW'(MUL_STEPS);
      acc_d  = is_div ? {{W{1'b0}}, a} : '0;
      mpl_d  = a;
      dvs_d  = b;
    end else if (busy_q) begin
      acc_d  = acc_nx;
      mpl_d  = mpl_q >> STEP_SB;
      cnt_d  = cnt_q - CW'(1);
      busy_d = (cnt_q != CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      mpl_q  <= '0;
      dvs_q  <= '0;
    end else begin
      busy_q <= busy_d;
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      mpl_q  <= mpl_d;
      dvs_q  <= dvs_d;
    end
  end

  assign busy   = busy_q;
  assign fin    = busy_q && (cnt_q == CW'(1));
  assign res_lo = acc_nx[W-1:0];
  assign res_hi = acc_nx[2*W-1:W];
  assign ov     = div_q ? (dvs_q == '0) : (acc_nx[2*W-1:W] != '0);

  // R6 / R7: the step counter stays within the longest iteration count
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0) && (cnt_q <= CW'(DIV_STEPS)));

  // R11: the control never reloads operands while iterating
  p_no_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !busy_q);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu8_pkg::*;
#(
  parameter int unsigned W       = DATA_W,
  parameter int unsigned STEP_SB = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [7:0]   psw_o,
  output logic         done_o
);

  op_e opc;
  assign opc = op_e'(op_i);

  logic [W-1:0] a_q, a_d, b_q, b_d;
  logic         cy_q, cy_d, ac_q, ac_d, f0_q, f0_d, ov_q, ov_d, p_q, p_d;
  logic [1:0]   rs_q, rs_d;
  logic         done_q, done_d;

  logic         md_busy, md_fin, md_ov, md_ld, accept, is_md;
  logic [W-1:0] md_lo, md_hi;
  logic [W-1:0] ar_res;
  logic         ar_cy, ar_ac, ar_ov;

  assign accept = start_i && !md_busy;
  assign is_md  = (opc == OP_MUL) || (opc == OP_DIV);
  assign md_ld  = accept && is_md;

  alu8_arith #(.W(W)) u_arith (
    .op   (opc),
    .a    (a_q),
    .opnd (opnd_i),
    .cy_i (cy_q),
    .ac_i (ac_q),
    .res  (ar_res),
    .cy_o (ar_cy),
    .ac_o (ar_ac),
    .ov_o (ar_ov)
  );

  alu8_muldiv #(.W(W), .STEP_SB(STEP_SB)) u_muldiv (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (md_ld),
    .is_div (opc == OP_DIV),
    .a      (a_q),
    .b      (b_q),
    .busy   (md_busy),
    .fin    (md_fin),
    .res_lo (md_lo),
    .res_hi (md_hi),
    .ov     (md_ov)
  );

  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    cy_d   = cy_q;
    ac_d   = ac_q;
    f0_d   = f0_q;
    rs_d   = rs_q;
    ov_d   = ov_q;
    done_d = 1'b0;
    if (accept) begin
      done_d = !is_md;
      case (opc)
        OP_ADD, OP_ADDC, OP_SUBB: begin
          a_d  = ar_res;
          cy_d = ar_cy;
          ac_d = ar_ac;
          ov_d = ar_ov;
        end
        OP_INC, OP_DEC: a_d = ar_res;
        OP_DA: begin
          a_d  = ar_res;
          cy_d = ar_cy;
        end
        OP_LDA: a_d = opnd_i;
        OP_LDB: b_d = opnd_i;
        OP_LDPSW: begin
          cy_d = opnd_i[7];
          ac_d = opnd_i[6];
          f0_d = opnd_i[5];
          rs_d = opnd_i[4:3];
          ov_d = opnd_i[2];
        end
        default: ;
      endcase
    end
    if (md_fin) begin
      a_d    = md_lo;
      b_d    = md_hi;
      cy_d   = 1'b0;
      ov_d   = md_ov;
      done_d = 1'b1;
    end
    p_d = ^a_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      cy_q   <= 1'b0;
      ac_q   <= 1'b0;
      f0_q   <= 1'b0;
      rs_q   <= 2'b00;
      ov_q   <= 1'b0;
      p_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      cy_q   <= cy_d;
      ac_q   <= ac_d;
      f0_q   <= f0_d;
      rs_q   <= rs_d;
      ov_q   <= ov_d;
      p_q    <= p_d;
      done_q <= done_d;
    end
  end

  assign a_o    = a_q;
  assign b_o    = b_q;
  assign psw_o  = {cy_q, ac_q, f0_q, rs_q, ov_q, 1'b0, p_q};
  assign done_o = done_q;

  // R5: increment and decrement never disturb the carry flag
  p_incdec_cy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ((opc == OP_INC) || (opc == OP_DEC))) |=> $stable(cy_q));

  // R6 / R7: a finished iterative operation leaves CY clear and signals done
  p_muldiv_cy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    md_fin |=> (!cy_q && done_q));

  // R11: A and B hold while the iterative unit works
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (md_busy && !md_fin) |=> ($stable(a_q) && $stable(b_q)));

  // R12: F0 and bank select move only on a status load
  p_bank_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && (opc == OP_LDPSW)) |=> ($stable(f0_q) && $stable(rs_q)));

  // R12: done follows exactly an accepted single-clock op or an iterative finish
  p_done_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((accept && !is_md) || md_fin) |=> done_q);
  p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !((accept && !is_md) || md_fin) |=> !done_q);

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [3:0] op_i;
  logic [7:0] opnd_i;
  logic [7:0] a_o, b_o, psw_o;
  logic       done_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [7:0] ma, mb;
  logic       mcy, mac, mf0, mov;
  logic [1:0] mrs;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu i_acc_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .opnd_i  (opnd_i),
    .a_o     (a_o),
    .b_o     (b_o),
    .psw_o   (psw_o),
    .done_o  (done_o)
  );

  function automatic logic [7:0] exp_psw();
    return {mcy, mac, mf0, mrs, mov, 1'b0, ^ma};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // advance the reference model; returns expected latency in edges
  task automatic model(input logic [3:0] o, input logic [7:0] d,
                       output int lat, output bit ab_undef, output string tag);
    int s, q;
    lat = 1; ab_undef = 0; tag = "R11";
    case (o)
      4'h0, 4'h1: begin
        int c;
        c   = (o == 4'h1) ? int'(mcy) : 0;
        s   = int'(ma) + int'(d) + c;
        mac = (int'(ma & 8'h0F) + int'(d & 8'h0F) + c) > 15;
        mov = (ma[7] == d[7]) && (s[7] != ma[7]);
        mcy = s > 255;
        ma  = s[7:0];
        tag = "R3";
      end
      4'h2: begin
        int c;
        c   = int'(mcy);
        s   = int'(ma) - int'(d) - c;
        mac = int'(ma & 8'h0F) < (int'(d & 8'h0F) + c);
        mov = (ma[7] != d[7]) && (s[7] != ma[7]);
        mcy = s < 0;
        ma  = s[7:0];
        tag = "R4";
      end
      4'h3: begin ma = ma + 8'd1; tag = "R5"; end
      4'h4: begin ma = ma - 8'd1; tag = "R5"; end
      4'h5: begin
        s   = int'(ma) * int'(mb);
        mov = s > 255;
        mcy = 1'b0;
        ma  = s[7:0];
        mb  = s[15:8];
        lat = 5; tag = "R6";
      end
      4'h6: begin
        lat = 9; mcy = 1'b0;
        if (mb == 8'h00) begin
          mov = 1'b1; ab_undef = 1; tag = "R8";
          ma = 8'h00;
        end else begin
          q = int'(ma) / int'(mb);
          s = int'(ma) % int'(mb);
          mov = 1'b0;
          ma = q[7:0]; mb = s[7:0];
          tag = "R7";
        end
      end
      4'h7: begin
        s = int'(ma);
        if ((ma[3:0] > 4'd9) || mac) s = s + 6;
        if ((((s >> 4) & 15) > 9) || mcy || (s > 255)) s = s + 96;
        if (s > 255) mcy = 1'b1;
        ma = s[7:0];
        tag = "R9";
      end
      4'h8: begin ma = d; tag = "R2"; end
      4'h9: begin mb = d; tag = "R2"; end
      4'hA: begin
        mcy = d[7]; mac = d[6]; mf0 = d[5]; mrs = d[4:3]; mov = d[2];
        tag = "R2";
      end
      default: ;
    endcase
  endtask

  task automatic compare(input string tag, input bit ab_undef);
    if (!ab_undef) begin
      chk({tag, " A"}, a_o, ma);
      chk({tag, " B"}, b_o, mb);
      chk({tag, " status"}, psw_o, exp_psw());
    end else begin
      ma = a_o; mb = b_o;   // R8: A/B unspecified, adopt them
      chk({tag, " CY"}, psw_o[7], 0);
      chk({tag, " OV"}, psw_o[2], 1);
    end
    chk("R10 parity", psw_o[0], ^a_o);
    chk("R12 F0/bank", psw_o[5:3], {mf0, mrs});
  endtask

  task automatic run_op(input logic [3:0] o, input logic [7:0] d);
    int lat, got;
    bit ab_undef;
    string tag;
    model(o, d, lat, ab_undef, tag);
    @(negedge clk);
    start_i = 1'b1; op_i = o; opnd_i = d;
    @(negedge clk);
    start_i = 1'b0;
    got = 1;
    while (!done_o && got < 20) begin
      @(negedge clk);
      got++;
    end
    chk({tag, " latency"}, got, lat);
    compare(tag, ab_undef);
    @(negedge clk);
    chk("R12 done pulse", done_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, got;
    bit ab_undef;
    string tag;
    void'($urandom(32'd5179));
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; opnd_i = '0;
    ma = 0; mb = 0; mcy = 0; mac = 0; mf0 = 0; mov = 0; mrs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 A", a_o, 0);
    chk("R1 B", b_o, 0);
    chk("R1 status", psw_o, 0);
    chk("R1 done", done_o, 0);

    // R2 loads, including the unused status bit
    run_op(4'hA, 8'hFF);
    chk("R2 bit1 zero", psw_o[1], 0);
    run_op(4'hA, 8'h00);

    // R9 BCD example: 53 + 58 then correct -> 11, CY=1
    run_op(4'h8, 8'h53);
    run_op(4'h0, 8'h58);
    chk("R3 sum AB", a_o, 8'hAB);
    run_op(4'h7, 8'h00);
    chk("R9 BCD 11", a_o, 8'h11);
    chk("R9 CY set", psw_o[7], 1);
    // R9 CY already set stays set
    run_op(4'h8, 8'h02);
    run_op(4'h7, 8'h00);
    chk("R9 CY kept", psw_o[7], 1);

    // R5 wrap with CY held at 1 then 0
    run_op(4'hA, 8'h80);
    run_op(4'h8, 8'hFF);
    run_op(4'h3, 8'h00);
    chk("R5 inc wrap", a_o, 8'h00);
    chk("R5 CY held", psw_o[7], 1);
    run_op(4'h4, 8'h00);
    chk("R5 dec wrap", a_o, 8'hFF);

    // R6 multiply example
    run_op(4'h8, 8'h45);
    run_op(4'h9, 8'hF5);
    run_op(4'h5, 8'h00);
    chk("R6 low", a_o, 8'h09);
    chk("R6 high", b_o, 8'h42);
    chk("R6 OV", psw_o[2], 1);
    run_op(4'h8, 8'h0F);
    run_op(4'h9, 8'h11);
    run_op(4'h5, 8'h00);
    chk("R6 no OV", psw_o[2], 0);

    // R7 divide, R8 divide by zero
    run_op(4'h8, 8'hFB);
    run_op(4'h9, 8'h12);
    run_op(4'h6, 8'h00);
    chk("R7 quotient", a_o, 8'h0D);
    chk("R7 remainder", b_o, 8'h11);
    run_op(4'h9, 8'h00);
    run_op(4'h6, 8'h00);

    // R11 unassigned selects
    run_op(4'hA, 8'hFC);
    for (int k = 11; k < 16; k++) run_op(4'(k), 8'hA5);

    // R11 start while busy is ignored
    run_op(4'h8, 8'h23);
    run_op(4'h9, 8'h07);
    model(4'h5, 8'h00, lat, ab_undef, tag);
    @(negedge clk);
    start_i = 1'b1; op_i = 4'h5; opnd_i = 8'h00;
    @(negedge clk);
    op_i = 4'h8; opnd_i = 8'h77;
    @(negedge clk);
    op_i = 4'hA; opnd_i = 8'hFF;
    @(negedge clk);
    start_i = 1'b0;
    got = 3;
    while (!done_o && got < 20) begin
      @(negedge clk);
      got++;
    end
    chk("R11 busy latency", got, lat);
    compare("R11", 1'b0);
    @(negedge clk);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] o;
      logic [7:0] d;
      o = 4'($urandom % 11);
      d = 8'($urandom);
      if (o == 4'h9 && ($urandom % 8) == 0) d = 8'h00;
      run_op(o, d);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule